// File: doc/BRIEF.md
# Multi-Mode Chip Select Generator

This block drives the active-low chip-select lines of an external bus controller. There is one line per address window. A decoder outside the block supplies a window-hit vector that is valid when the address-latch strobe (`ale`) falls. Each line is set up by its own 2-bit mode field. In address mode the line is held for as long as the bus keeps addressing its window. In the three strobe modes the line is asserted only while the read strobe, a write strobe, or either of them is active, and only for the window that was hit by the current bus cycle.

A small phase machine follows the latch strobe through `PH_IDLE`, `PH_ADDR` and `PH_DATA`. The transitions are: IDLE→ADDR when `ale` rises, ADDR→DATA when `ale` falls, and DATA→ADDR when `ale` rises again. Leaving ADDR with `ale` low is the falling-edge event. On that event the window tracker picks the lowest-numbered window that was hit and updates two vectors. The held vector records address-mode ownership. The current vector records the window of the ongoing cycle. Every output comes from a flip-flop, so decode hazards never reach the pins.

Top module: `multimode_cs_gen`

## Requirements
- R1: The mode field of line i is `cs_cfg[2i+1:2i]` = {write enable, read enable}. 00 selects address mode, 01 read mode, 10 write mode and 11 read/write mode.
- R2: A line in address mode goes low one clock after the edge that first samples `ale` low following a high sample, provided its window wins that cycle.
- R3: An address-mode line stays low through strobes and through later cycles to the same window. It is released at the falling-edge event of a cycle that addresses any other window.
- R4: A read-mode line is low, one clock after sampling, exactly while `rd_n` is sampled low during a cycle to its window. Write strobes do not assert it.
- R5: A write-mode line is low, one clock after sampling, while `wrh_n` or `wrl_n` is sampled low during a cycle to its window. `rd_n` does not assert it.
- R6: A read/write-mode line is low while any of `rd_n`, `wrh_n` or `wrl_n` is sampled low during a cycle to its window.
- R7: A falling-edge event with an all-zero hit vector, or one that hits a strobe-mode window, releases every held address-mode line.
- R8: During and right after reset, line 0 is low (address mode, held) and all other lines are high.
- R9: When several hit bits are set, the lowest-numbered window wins.
- R10: At most one chip-select line is low in any cycle. All outputs are registered.
- R11: A strobe-mode line whose window is not the current one stays high whatever the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address-latch strobe, active high |
| win_hit | input | N_LINES | Decoded window hit vector, sampled at the falling-edge event |
| cs_cfg | input | 2*N_LINES | Per-line mode fields {write enable, read enable} |
| rd_n | input | 1 | Read strobe, active low |
| wrh_n | input | 1 | High-byte write strobe, active low |
| wrl_n | input | 1 | Low-byte write strobe, active low |
| cs_n | output | N_LINES | Chip-select outputs, active low, registered |

## Verification
The bench builds the block with its default of four lines. Four lines are enough to place address, read, write and read/write modes on distinct lines at the same time. They also allow multi-bit hit vectors in which a lower address-mode window beats a higher one. Random phases draw a fresh mode field for every line and mix clean one-hot hits with empty and multi-bit vectors. This reaches hand-overs between every pair of modes, as well as strobes that arrive while the latch strobe is high.

// File: rtl/csg_pkg.sv
package csg_pkg;

    typedef enum logic [1:0] {
        CSM_ADDR  = 2'b00,
        CSM_READ  = 2'b01,
        CSM_WRITE = 2'b10,
        CSM_RDWR  = 2'b11
    } cs_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } bus_phase_e;

endpackage

// File: rtl/csg_phase_fsm.sv
module csg_phase_fsm
    import csg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ale,
    output logic addr_fall
);

    bus_phase_e state_q;
    bus_phase_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (ale)  state_d = PH_ADDR;
            PH_ADDR: if (!ale) state_d = PH_DATA;
            PH_DATA: if (ale)  state_d = PH_ADDR;
            default:           state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        addr_fall = (state_q == PH_ADDR) && !ale;
    end

    // R2: the falling-edge event moves the phase into the data phase
    a_r2_fall_to_data: assert property (@(posedge clk) disable iff (!rst_n)
        addr_fall |=> (state_q == PH_DATA));

    a_r2_no_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_IDLE) |=> (state_q != PH_IDLE));

endmodule

// File: rtl/csg_window_track.sv
module csg_window_track #(
    parameter int N_LINES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_fall,
    input  logic [N_LINES-1:0] win_hit,
    input  logic [N_LINES-1:0] addr_mode,
    output logic [N_LINES-1:0] held_d,
    output logic [N_LINES-1:0] cur_d
);

    localparam logic [N_LINES-1:0] RST_VEC = {{(N_LINES-1){1'b0}}, 1'b1};

    logic [N_LINES-1:0] held_q;
    logic [N_LINES-1:0] cur_q;
    logic [N_LINES-1:0] winner;

    always_comb begin
        winner = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (win_hit[i]) winner = N_LINES'(1) << i;
        end
    end

    always_comb begin
        held_d = held_q;
        cur_d  = cur_q;
        if (addr_fall) begin
            cur_d  = winner;
            held_d = winner & addr_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= RST_VEC;
            cur_q  <= RST_VEC;
        end else begin
            held_q <= held_d;
            cur_q  <= cur_d;
        end
    end

    // R3: held lines change only on a falling-edge event
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_fall |=> $stable(held_q));

    // R7: empty hit vector releases every held line
    a_r7_empty_release: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_fall && (win_hit == '0)) |=> (held_q == '0));

    // R9: single winner
    a_r9_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cur_q) && $onehot0(held_q));

endmodule

// File: rtl/csg_line.sv
module csg_line
    import csg_pkg::*;
#(
    parameter bit RST_LOW = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_bits,
    input  logic       held,
    input  logic       cur,
    input  logic       rd_act,
    input  logic       wr_act,
    output logic       cs_n
);

    cs_mode_e mode;
    logic     gate;

    always_comb begin
        mode = cs_mode_e'(mode_bits);
        gate = 1'b0;
        unique case (mode)
            CSM_ADDR:  gate = 1'b0;
            CSM_READ:  gate = rd_act;
            CSM_WRITE: gate = wr_act;
            CSM_RDWR:  gate = rd_act | wr_act;
            default:   gate = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_n <= !RST_LOW;
        else        cs_n <= !(held | (cur & gate));
    end

    // R4: read-mode line ignores the write strobes
    a_r4_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CSM_READ && !rd_act && !held) |=> cs_n);

    // R5: write-mode line ignores the read strobe
    a_r5_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CSM_WRITE && !wr_act && !held) |=> cs_n);

    // R11: a line that is neither held nor current stays inactive
    a_r11_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !cur) |=> cs_n);

endmodule

// File: rtl/multimode_cs_gen.sv
module multimode_cs_gen #(
    parameter int N_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale,
    input  logic [N_LINES-1:0]   win_hit,
    input  logic [2*N_LINES-1:0] cs_cfg,
    input  logic                 rd_n,
    input  logic                 wrh_n,
    input  logic                 wrl_n,
    output logic [N_LINES-1:0]   cs_n
);

    localparam int CFG_W = 2;

    logic               addr_fall;
    logic [N_LINES-1:0] addr_mode;
    logic [N_LINES-1:0] held_d;
    logic [N_LINES-1:0] cur_d;
    logic               rd_act;
    logic               wr_act;

    always_comb begin
        rd_act = !rd_n;
        wr_act = !wrh_n || !wrl_n;
    end

    csg_phase_fsm u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale       (ale),
        .addr_fall (addr_fall)
    );

    csg_window_track #(.N_LINES(N_LINES)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_fall (addr_fall),
        .win_hit   (win_hit),
        .addr_mode (addr_mode),
        .held_d    (held_d),
        .cur_d     (cur_d)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign addr_mode[i] = (cs_cfg[CFG_W*i +: CFG_W] == 2'b00);

        csg_line #(.RST_LOW(i == 0)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_bits (cs_cfg[CFG_W*i +: CFG_W]),
            .held      (held_d[i]),
            .cur       (cur_d[i]),
            .rd_act    (rd_act),
            .wr_act    (wr_act),
            .cs_n      (cs_n[i])
        );
    end

    // R10: never two selects low together
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R8: after reset line 0 is the only active line
    a_r8_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cs_n == ~{{(N_LINES-1){1'b0}}, 1'b1}));

endmodule

// File: tb/multimode_cs_gen_tb_top.sv
module multimode_cs_gen_tb_top;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ale = 1'b0;
    logic [N-1:0]   win_hit = '0;
    logic [2*N-1:0] cs_cfg = '0;
    logic           rd_n = 1'b1;
    logic           wrh_n = 1'b1;
    logic           wrl_n = 1'b1;
    logic [N-1:0]   cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] m_held, m_cur, exp_cs;
    logic         m_addr;

    always #4 clk = !clk;

    multimode_cs_gen #(.N_LINES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .ale(ale), .win_hit(win_hit),
        .cs_cfg(cs_cfg), .rd_n(rd_n), .wrh_n(wrh_n), .wrl_n(wrl_n),
        .cs_n(cs_n)
    );

    function automatic int lowest(input logic [N-1:0] h);
        for (int i = 0; i < N; i++) if (h[i]) return i;
        return -1;
    endfunction

    task automatic model_edge();
        int  w;
        bit  fall, rd, wr, g;
        logic [1:0] md;
        w    = lowest(win_hit);
        fall = m_addr && !ale;
        if (fall) begin
            m_cur  = '0;
            m_held = '0;
            if (w >= 0) begin
                m_cur[w] = 1'b1;
                if (cs_cfg[2*w +: 2] == 2'b00) m_held[w] = 1'b1;
            end
        end
        m_addr = ale;
        rd = !rd_n;
        wr = !wrh_n || !wrl_n;
        for (int i = 0; i < N; i++) begin
            md = cs_cfg[2*i +: 2];
            g  = (md[0] && rd) || (md[1] && wr);
            exp_cs[i] = !(m_held[i] || (m_cur[i] && g));
        end
    endtask

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cs_n=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag, input bit a, input logic [N-1:0] h,
                       input bit r, input bit wh, input bit wl);
        @(negedge clk);
        ale = a; win_hit = h; rd_n = r; wrh_n = wh; wrl_n = wl;
        model_edge();
        @(posedge clk);
        #2;
        check(tag, cs_n, exp_cs);
        checks++;
        if (!$onehot0(~cs_n)) begin
            errors++;
            $display("FAIL R10: cs_n=%b expected at most one low", cs_n);
        end
    endtask

    // one bus cycle: address phase then data phase with a strobe pattern
    task automatic bus(input string tag, input logic [N-1:0] h,
                       input bit r, input bit wh, input bit wl, input int len);
        cyc(tag, 1'b1, h, 1'b1, 1'b1, 1'b1);
        cyc(tag, 1'b0, h, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < len; k++) cyc(tag, 1'b0, h, r, wh, wl);
        cyc(tag, 1'b0, h, 1'b1, 1'b1, 1'b1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        m_held = 4'b0001; m_cur = 4'b0001; m_addr = 1'b0; exp_cs = 4'b1110;
        // line3 rd/wr, line2 addr, line1 read, line0 addr (R1 encodings)
        cs_cfg = 8'b11_00_01_00;
        repeat (3) begin
            @(negedge clk);
            check("R8 in reset", cs_n, 4'b1110);
        end
        @(negedge clk);
        rst_n = 1'b1;
        cyc("R8 after reset", 1'b0, '0, 1'b1, 1'b1, 1'b1);
        check("R8 line0 held", cs_n, 4'b1110);

        bus("R2 address select", 4'b0100, 1'b0, 1'b1, 1'b1, 2);
        check("R2 line2 held", cs_n, 4'b1011);
        bus("R3 same window", 4'b0100, 1'b1, 1'b1, 1'b0, 2);
        check("R3 still held", cs_n, 4'b1011);

        bus("R4 read window", 4'b0010, 1'b0, 1'b1, 1'b1, 3);
        check("R3 released by other window", cs_n, 4'b1111);
        cyc("R4 read low", 1'b0, 4'b0010, 1'b0, 1'b1, 1'b1);
        check("R4 read active", cs_n, 4'b1101);
        cyc("R4 write ignored", 1'b0, 4'b0010, 1'b1, 1'b0, 1'b0);
        check("R4 write ignored", cs_n, 4'b1111);

        bus("R6 rdwr write", 4'b1000, 1'b1, 1'b1, 1'b0, 2);
        cyc("R6 wrl", 1'b0, 4'b1000, 1'b1, 1'b1, 1'b0);
        check("R6 wrl active", cs_n, 4'b0111);
        cyc("R6 rd", 1'b0, 4'b1000, 1'b0, 1'b1, 1'b1);
        check("R6 rd active", cs_n, 4'b0111);
        check("R11 read line1 not current", cs_n[1], 1'b1);

        bus("R7 hold line0", 4'b0001, 1'b0, 1'b1, 1'b1, 1);
        check("R7 line0 held", cs_n, 4'b1110);
        bus("R7 empty hit", 4'b0000, 1'b0, 1'b1, 1'b1, 1);
        check("R7 all released", cs_n, 4'b1111);
        bus("R7 hold line2", 4'b0100, 1'b1, 1'b1, 1'b1, 1);
        bus("R7 strobe window", 4'b0010, 1'b1, 1'b1, 1'b1, 1);
        check("R7 released by strobe window", cs_n, 4'b1111);

        bus("R9 priority", 4'b1101, 1'b1, 1'b1, 1'b1, 1);
        check("R9 lowest wins", cs_n, 4'b1110);
        bus("R9 priority", 4'b1100, 1'b0, 1'b1, 1'b1, 1);
        check("R9 line2 over line3", cs_n, 4'b1011);

        // line1 to write mode (R1 code 10)
        cs_cfg = 8'b11_00_10_00;
        bus("R5 write window", 4'b0010, 1'b1, 1'b0, 1'b1, 2);
        cyc("R5 wrh", 1'b0, 4'b0010, 1'b1, 1'b0, 1'b1);
        check("R5 wrh active", cs_n, 4'b1101);
        cyc("R5 wrl", 1'b0, 4'b0010, 1'b1, 1'b1, 1'b0);
        check("R5 wrl active", cs_n, 4'b1101);
        cyc("R5 rd ignored", 1'b0, 4'b0010, 1'b0, 1'b1, 1'b1);
        check("R5 rd ignored", cs_n, 4'b1111);

        for (int p = 0; p < 20; p++) begin
            @(negedge clk);
            cs_cfg = 8'($urandom);
            for (int s = 0; s < 100; s++) begin
                logic [N-1:0] h;
                int sel;
                sel = int'($urandom_range(0, 9));
                if (sel < 7)      h = 4'b0001 << $urandom_range(0, N-1);
                else if (sel < 8) h = '0;
                else              h = 4'($urandom);
                cyc("R10 random", $urandom_range(0, 3) == 0, h,
                    $urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0,
                    $urandom_range(0, 2) != 0);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule